// File: doc/BRIEF.md
# Blit Address Sequencer with Tile Wrap

This block produces the memory addresses for a rectangular two-dimensional block transfer. A launch pulse latches a parameter set: the start addresses of the pattern, source and destination planes, a row pitch for each, a wrap code for the pattern and one for the source, two direction bits, the X and Y counts and a routing code. From then on the block hands out one address triple per pixel: a pattern read address, a source read address and a destination write address. The raster operation and the memory access happen elsewhere. That consumer takes each triple through a valid/acknowledge handshake.

The pattern and source planes are small tiles addressed as a base plus an X offset. The X offset wraps under a power-of-two mask and the row index wraps after a set number of rows. At each wrap the base reloads: the pattern base from its tile-aligned launch value and the source base from the programmed source address. Each direction bit flips its axis. Bit 0 makes fetches walk backwards and the destination decrement. Bit 1 makes row advances subtract the pitch. The pixel engine requests runs of pixels with a step request and a length. When the routing code marks a CPU-fed transfer, a run also stops at every row end so the next batch of host data can arrive.

Top module: `blit_addr_seq`

## Requirements
- R1: Wrap code bits 2:0 select the X mask (codes 0 and 1 give 0, codes 2 to 6 give 2^code−1, code 7 gives all ones). Bits 6:4 select the row count (codes 0 to 3 give 2^code rows, codes 4 to 7 mean no Y wrap).
- R2: At launch the pattern X offset is the pattern address ANDed with the X mask, and the base has those bits cleared. When bit 7 of the pattern wrap code is clear and Y wraps, the row index starts at (base ÷ (mask+1)) mod rows, and the base is aligned down to a multiple of (mask+1)×rows.
- R3: With direction bit 0 clear, each pattern and source address is base + X offset, the destination increments by one per pixel, and both X offsets step by one under their own mask.
- R4: With direction bit 0 set, the fetch addresses are base − X offset and the destination decrements by one per pixel.
- R5: After the pixel whose X position equals count X, the pattern and source bases move by pitch+1 and the destination becomes the saved row start moved by pitch+1 (subtracted when direction bit 1 is set). The pattern X offset returns to its launch value and the source X offset returns to 0.
- R6: At each row end a row index that reaches its row count resets to 0 and its base reloads: the pattern base from its aligned launch value and the source base from the programmed source address.
- R7: Counts hold N−1. Busy rises at launch and falls right after the last pixel of the row whose Y position equals count Y.
- R8: When routing bits 1:0 are nonzero, a run also ends at each row end. busy stays high and step_done pulses.
- R9: A step request accepted while busy and not running starts a run of at most step_len pixels and ends with a one-cycle step_done. A zero length gives step_done at once with no pixel. A step request while idle or during a run is ignored.
- R10: All three addresses are 21 bits wide and wrap modulo 2^21.
- R11: The status byte carries busy in bit 2 and source-from-screen in bit 3. Source-from-screen is set at launch when routing bits 2:0 are zero or routing bit 2 is set. All other status bits are 0.
- R12: addr_valid is high only during a run. While it is high without mem_ack, all three addresses hold.
- R13: After reset, busy, addr_valid, step_done and status are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| launch | input | 1 | Latch parameters and start a transfer |
| pat_start | input | 21 | Pattern start address |
| src_start | input | 21 | Source start address |
| dst_start | input | 21 | Destination start address |
| pat_pitch | input | 16 | Pattern row pitch minus one |
| src_pitch | input | 16 | Source row pitch minus one |
| dst_pitch | input | 16 | Destination row pitch minus one |
| pat_wrap | input | 8 | Pattern wrap code |
| src_wrap | input | 8 | Source wrap code |
| xy_dir | input | 2 | Bit 0 reverse X, bit 1 reverse Y |
| count_x | input | 16 | Pixels per row minus one |
| count_y | input | 16 | Rows minus one |
| routing | input | 3 | Data routing code |
| step_req | input | 1 | Request a run of pixels |
| step_len | input | 16 | Maximum pixels in the run |
| mem_ack | input | 1 | Consumer accepts the current triple |
| addr_valid | output | 1 | Address triple is valid |
| pat_addr | output | 21 | Pattern read address |
| src_addr | output | 21 | Source read address |
| dst_addr | output | 21 | Destination write address |
| step_done | output | 1 | One-cycle pulse at run end |
| busy | output | 1 | Transfer in progress |
| status | output | 8 | Status byte |

## Verification
A wrong tile offset or row index shows up at once on pat_addr or src_addr, on the first triple after launch or after the next row end. The bench compares every offered triple, including repeats while mem_ack is low, against a model built from the requirements. Any divergence therefore fails within one pixel of its cause. A fault in the row or run counters instead appears as step_done or the fall of busy arriving at the wrong pixel. The bench checks both at the cycle after each acknowledged pixel.

// File: rtl/blit_seq_pkg.sv
package blit_seq_pkg;
    localparam int ADDR_W = 21;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t      base;
        addr_t      xoff;
        logic [2:0] yidx;
    } chan_start_t;

    // X wrap mask from wrap code bits 2:0
    function automatic addr_t wrap_xmask(input logic [2:0] c);
        case (c)
            3'd0, 3'd1: return '0;
            3'd7:       return '1;
            default:    return addr_t'((32'd1 << c) - 32'd1);
        endcase
    endfunction

    function automatic int unsigned wrap_xshift(input logic [2:0] c);
        case (c)
            3'd0, 3'd1: return 0;
            3'd7:       return ADDR_W;
            default:    return int'(c);
        endcase
    endfunction

    // Row count from wrap code bits 6:4, 0 means no Y wrap
    function automatic logic [3:0] wrap_rows(input logic [2:0] c);
        return c[2] ? 4'd0 : (4'd1 << c[1:0]);
    endfunction

    // Launch-time alignment of a tiled plane
    function automatic chan_start_t tile_align(input addr_t a, input logic [7:0] w);
        chan_start_t o;
        addr_t       m;
        addr_t       b;
        logic [3:0]  r;
        logic [31:0] span;
        int unsigned sh;
        m      = wrap_xmask(w[2:0]);
        r      = wrap_rows(w[6:4]);
        sh     = wrap_xshift(w[2:0]);
        b      = a & ~m;
        o.xoff = a & m;
        o.base = b;
        o.yidx = '0;
        if (!w[7] && r != 4'd0) begin
            o.yidx = 3'((b >> sh) & addr_t'(r - 4'd1));
            span   = (32'(r) << sh) - 32'd1;
            o.base = b & ~addr_t'(span);
        end
        return o;
    endfunction
endpackage

// File: rtl/blit_fetch_chan.sv
module blit_fetch_chan
    import blit_seq_pkg::*;
#(
    parameter int PITCH_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  chan_start_t        start_val,
    input  addr_t              reload_base,
    input  logic [7:0]         wrap,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [1:0]         dir,
    input  logic               pix_adv,
    input  logic               row_adv,
    output addr_t              fetch_addr
);
    addr_t      base, xoff, xstart, reload_q, xmask, row_step;
    logic [2:0] yidx;
    logic [3:0] rows;
    logic [1:0] dir_q;
    logic       y_hit;

    assign row_step   = addr_t'(pitch_q) + addr_t'(1);
    assign y_hit      = (rows != 4'd0) && ({1'b0, yidx} + 4'd1 == rows);
    assign fetch_addr = dir_q[0] ? (base - xoff) : (base + xoff);

    logic [PITCH_W-1:0] pitch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0; xoff <= '0; xstart <= '0; reload_q <= '0;
            xmask <= '0; yidx <= '0; rows <= '0; dir_q <= '0; pitch_q <= '0;
        end else if (load) begin
            base     <= start_val.base;
            xoff     <= start_val.xoff;
            xstart   <= start_val.xoff;
            yidx     <= start_val.yidx;
            reload_q <= reload_base;
            xmask    <= wrap_xmask(wrap[2:0]);
            rows     <= wrap_rows(wrap[6:4]);
            dir_q    <= dir;
            pitch_q  <= pitch;
        end else if (row_adv) begin
            xoff <= xstart;
            if (y_hit) begin
                yidx <= '0;
                base <= reload_q;
            end else begin
                yidx <= yidx + 3'd1;
                base <= dir_q[1] ? (base - row_step) : (base + row_step);
            end
        end else if (pix_adv) begin
            xoff <= (xoff + addr_t'(1)) & xmask;
        end
    end

    a_r3_xoff_in_mask: assert property (@(posedge clk) disable iff (rst)
        (xoff & ~xmask) == '0);
    a_r6_yidx_below_rows: assert property (@(posedge clk) disable iff (rst)
        rows != 4'd0 |-> {1'b0, yidx} < rows);
endmodule

// File: rtl/blit_dst_chan.sv
module blit_dst_chan
    import blit_seq_pkg::*;
#(
    parameter int PITCH_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  addr_t              start_addr,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [1:0]         dir,
    input  logic               pix_adv,
    input  logic               row_adv,
    output addr_t              wr_addr
);
    addr_t              cur, row_start, next_row;
    logic [PITCH_W-1:0] pitch_q;
    logic [1:0]         dir_q;

    assign next_row = dir_q[1] ? (row_start - (addr_t'(pitch_q) + addr_t'(1)))
                               : (row_start + (addr_t'(pitch_q) + addr_t'(1)));
    assign wr_addr  = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0; row_start <= '0; pitch_q <= '0; dir_q <= '0;
        end else if (load) begin
            cur       <= start_addr;
            row_start <= start_addr;
            pitch_q   <= pitch;
            dir_q     <= dir;
        end else if (row_adv) begin
            cur       <= next_row;
            row_start <= next_row;
        end else if (pix_adv) begin
            cur <= dir_q[0] ? (cur - addr_t'(1)) : (cur + addr_t'(1));
        end
    end

    a_r5_rowstart_moves_only_at_row_end: assert property (@(posedge clk) disable iff (rst)
        !load && !row_adv |=> $stable(row_start));
endmodule

// File: rtl/blit_run_ctrl.sv
module blit_run_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [CNT_W-1:0] count_x,
    input  logic [CNT_W-1:0] count_y,
    input  logic [2:0]       routing,
    input  logic             step_req,
    input  logic [CNT_W-1:0] step_len,
    input  logic             mem_ack,
    output logic             addr_valid,
    output logic             pix_adv,
    output logic             row_adv,
    output logic             step_done,
    output logic             busy,
    output logic             src_screen
);
    logic [CNT_W-1:0] cnt_x, cnt_y, pos_x, pos_y, left;
    logic             running, cpu_fed, last_pix, run_stop;

    assign addr_valid = running;
    assign pix_adv    = running && mem_ack;
    assign row_adv    = pix_adv && (pos_x == cnt_x);
    assign last_pix   = row_adv && (pos_y == cnt_y);
    assign run_stop   = (left == CNT_W'(1)) || last_pix || (row_adv && cpu_fed);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_x <= '0; cnt_y <= '0; pos_x <= '0; pos_y <= '0; left <= '0;
            running <= 1'b0; cpu_fed <= 1'b0; step_done <= 1'b0;
            busy <= 1'b0; src_screen <= 1'b0;
        end else if (launch) begin
            busy       <= 1'b1;
            src_screen <= (routing == 3'd0) || routing[2];
            cpu_fed    <= routing[1:0] != 2'd0;
            cnt_x      <= count_x;
            cnt_y      <= count_y;
            pos_x      <= '0;
            pos_y      <= '0;
            left       <= '0;
            running    <= 1'b0;
            step_done  <= 1'b0;
        end else begin
            step_done <= 1'b0;
            if (pix_adv) begin
                left  <= left - CNT_W'(1);
                pos_x <= row_adv ? '0 : pos_x + CNT_W'(1);
                if (row_adv) pos_y <= pos_y + CNT_W'(1);
                if (last_pix) busy <= 1'b0;
                if (run_stop) begin
                    running   <= 1'b0;
                    step_done <= 1'b1;
                end
            end else if (step_req && busy && !running) begin
                if (step_len == '0) begin
                    step_done <= 1'b1;
                end else begin
                    running <= 1'b1;
                    left    <= step_len;
                end
            end
        end
    end

    a_r12_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> busy);
    a_r7_busy_falls_after_pixel: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(addr_valid && mem_ack));
    a_r9_done_when_stopped: assert property (@(posedge clk) disable iff (rst)
        step_done |-> !addr_valid);
    a_r7_posx_in_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> pos_x <= cnt_x);
    a_r8_cpu_pause_at_row_end: assert property (@(posedge clk) disable iff (rst)
        row_adv && cpu_fed |=> !addr_valid);
endmodule

// File: rtl/blit_addr_seq.sv
module blit_addr_seq
    import blit_seq_pkg::*;
#(
    parameter int PITCH_W = 16,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               launch,
    input  logic [ADDR_W-1:0]  pat_start,
    input  logic [ADDR_W-1:0]  src_start,
    input  logic [ADDR_W-1:0]  dst_start,
    input  logic [PITCH_W-1:0] pat_pitch,
    input  logic [PITCH_W-1:0] src_pitch,
    input  logic [PITCH_W-1:0] dst_pitch,
    input  logic [7:0]         pat_wrap,
    input  logic [7:0]         src_wrap,
    input  logic [1:0]         xy_dir,
    input  logic [CNT_W-1:0]   count_x,
    input  logic [CNT_W-1:0]   count_y,
    input  logic [2:0]         routing,
    input  logic               step_req,
    input  logic [CNT_W-1:0]   step_len,
    input  logic               mem_ack,
    output logic               addr_valid,
    output logic [ADDR_W-1:0]  pat_addr,
    output logic [ADDR_W-1:0]  src_addr,
    output logic [ADDR_W-1:0]  dst_addr,
    output logic               step_done,
    output logic               busy,
    output logic [7:0]         status
);
    logic        pix_adv, row_adv, src_screen;
    chan_start_t pat_init, src_init;

    assign pat_init = tile_align(pat_start, pat_wrap);
    assign src_init = '{base: src_start, xoff: '0, yidx: '0};
    assign status   = {4'b0000, src_screen, busy, 2'b00};

    blit_run_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .launch(launch), .count_x(count_x), .count_y(count_y),
        .routing(routing), .step_req(step_req), .step_len(step_len), .mem_ack(mem_ack),
        .addr_valid(addr_valid), .pix_adv(pix_adv), .row_adv(row_adv),
        .step_done(step_done), .busy(busy), .src_screen(src_screen)
    );

    blit_fetch_chan #(.PITCH_W(PITCH_W)) u_pat (
        .clk(clk), .rst(rst), .load(launch), .start_val(pat_init),
        .reload_base(pat_init.base), .wrap(pat_wrap), .pitch(pat_pitch), .dir(xy_dir),
        .pix_adv(pix_adv), .row_adv(row_adv), .fetch_addr(pat_addr)
    );

    blit_fetch_chan #(.PITCH_W(PITCH_W)) u_src (
        .clk(clk), .rst(rst), .load(launch), .start_val(src_init),
        .reload_base(src_start), .wrap(src_wrap), .pitch(src_pitch), .dir(xy_dir),
        .pix_adv(pix_adv), .row_adv(row_adv), .fetch_addr(src_addr)
    );

    blit_dst_chan #(.PITCH_W(PITCH_W)) u_dst (
        .clk(clk), .rst(rst), .load(launch), .start_addr(dst_start), .pitch(dst_pitch),
        .dir(xy_dir), .pix_adv(pix_adv), .row_adv(row_adv), .wr_addr(dst_addr)
    );

    a_r12_hold_without_ack: assert property (@(posedge clk) disable iff (rst)
        addr_valid && !mem_ack && !launch |=>
            $stable(pat_addr) && $stable(src_addr) && $stable(dst_addr));
    a_r11_status_spare_bits_zero: assert property (@(posedge clk) disable iff (rst)
        status[7:4] == 4'd0 && status[1:0] == 2'd0);
endmodule

// File: tb/blit_addr_seq_test.sv
`timescale 1ns/1ps
module blit_addr_seq_test;
    localparam logic [31:0] AM = 32'h1FFFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        launch = 1'b0;
    logic [20:0] pat_start = '0, src_start = '0, dst_start = '0;
    logic [15:0] pat_pitch = '0, src_pitch = '0, dst_pitch = '0;
    logic [7:0]  pat_wrap = '0, src_wrap = '0;
    logic [1:0]  xy_dir = '0;
    logic [15:0] count_x = '0, count_y = '0, step_len = '0;
    logic [2:0]  routing = '0;
    logic        step_req = 1'b0, mem_ack = 1'b0;
    logic        addr_valid, step_done, busy;
    logic [20:0] pat_addr, src_addr, dst_addr;
    logic [7:0]  status;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    blit_addr_seq uut (
        .clk(clk), .rst(rst), .launch(launch), .pat_start(pat_start), .src_start(src_start),
        .dst_start(dst_start), .pat_pitch(pat_pitch), .src_pitch(src_pitch),
        .dst_pitch(dst_pitch), .pat_wrap(pat_wrap), .src_wrap(src_wrap), .xy_dir(xy_dir),
        .count_x(count_x), .count_y(count_y), .routing(routing), .step_req(step_req),
        .step_len(step_len), .mem_ack(mem_ack), .addr_valid(addr_valid),
        .pat_addr(pat_addr), .src_addr(src_addr), .dst_addr(dst_addr),
        .step_done(step_done), .busy(busy), .status(status)
    );

    // model state
    logic [31:0] m_pb, m_px, m_pxs, m_pm, m_prows, m_py, m_palign, m_pp;
    logic [31:0] m_sb, m_sx, m_sm, m_srows, m_sy, m_sorig, m_sp;
    logic [31:0] m_d, m_drow, m_dp, m_posx, m_posy, m_cx, m_cy;
    logic [1:0]  m_dir;
    logic        m_busy = 1'b0, m_cpu = 1'b0;
    string       m_tag = "R3";

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // R1: wrap decode and R2 alignment, written arithmetically
    task automatic m_tile(input logic [31:0] a, input logic [7:0] w,
                          output logic [31:0] base, output logic [31:0] px, output logic [31:0] py,
                          output logic [31:0] mask, output logic [31:0] rows);
        logic [31:0] tw;
        mask = (w[2:0] < 3'd2) ? 32'd0 : (w[2:0] == 3'd7) ? AM : ((32'd1 << w[2:0]) - 32'd1);
        rows = w[6] ? 32'd0 : (32'd1 << w[5:4]);
        py = 0;
        if (w[2:0] == 3'd7) begin
            px = a; base = 0;
        end else begin
            tw = mask + 1; px = a % tw; base = a - px;
            if (!w[7] && rows != 0) begin
                py = (base / tw) % rows;
                base = base - (base % (tw * rows));
            end
        end
    endtask

    function automatic logic [31:0] e_pat();
        return (m_dir[0] ? (m_pb - m_px) : (m_pb + m_px)) & AM;
    endfunction
    function automatic logic [31:0] e_src();
        return (m_dir[0] ? (m_sb - m_sx) : (m_sb + m_sx)) & AM;
    endfunction

    task automatic m_pixel(output logic stop);
        logic row_end, last;
        row_end = 1'b0; last = 1'b0;
        m_tag = m_dir[0] ? "R4" : "R3";
        m_px = (m_px + 1) & m_pm;
        m_sx = (m_sx + 1) & m_sm;
        m_d  = (m_dir[0] ? m_d - 1 : m_d + 1) & AM;
        m_posx++;
        if (m_posx > m_cx) begin
            row_end = 1'b1; m_tag = "R5";
            m_pb = m_dir[1] ? m_pb - (m_pp + 1) : m_pb + m_pp + 1;
            m_sb = m_dir[1] ? m_sb - (m_sp + 1) : m_sb + m_sp + 1;
            m_drow = (m_dir[1] ? m_drow - (m_dp + 1) : m_drow + m_dp + 1) & AM;
            m_d = m_drow;
            m_px = m_pxs; m_sx = 0;
            m_py++;
            if (m_prows != 0 && m_py == m_prows) begin m_py = 0; m_pb = m_palign; m_tag = "R6"; end
            m_sy++;
            if (m_srows != 0 && m_sy == m_srows) begin m_sy = 0; m_sb = m_sorig; m_tag = "R6"; end
            m_posy++;
            m_posx = 0;
            if (m_posy > m_cy) begin last = 1'b1; m_busy = 1'b0; end
        end
        stop = last || (row_end && m_cpu);
    endtask

    task automatic do_launch(input logic [20:0] p, input logic [20:0] s, input logic [20:0] d,
                             input logic [15:0] pp, input logic [15:0] sp, input logic [15:0] dp,
                             input logic [7:0] pw, input logic [7:0] sw, input logic [1:0] dir,
                             input logic [15:0] cx, input logic [15:0] cy, input logic [2:0] rt);
        logic [31:0] dummy;
        @(negedge clk);
        pat_start = p; src_start = s; dst_start = d;
        pat_pitch = pp; src_pitch = sp; dst_pitch = dp;
        pat_wrap = pw; src_wrap = sw; xy_dir = dir;
        count_x = cx; count_y = cy; routing = rt; launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
        m_tile({11'd0, p}, pw, m_pb, m_px, m_py, m_pm, m_prows);
        m_palign = m_pb; m_pxs = m_px;
        m_tile(32'd0, sw, dummy, dummy, dummy, m_sm, m_srows);
        m_sb = {11'd0, s}; m_sorig = m_sb; m_sx = 0; m_sy = 0;
        m_d = {11'd0, d}; m_drow = m_d;
        m_pp = {16'd0, pp}; m_sp = {16'd0, sp}; m_dp = {16'd0, dp};
        m_cx = {16'd0, cx}; m_cy = {16'd0, cy}; m_dir = dir;
        m_posx = 0; m_posy = 0; m_busy = 1'b1; m_cpu = rt[1:0] != 2'd0;
        m_tag = "R2";
        chk("R11", "status", {24'd0, status},
            {27'd0, (rt == 3'd0) || rt[2], 1'b1, 2'b00});
        chk("R7", "busy after launch", {31'd0, busy}, 32'd1);
    endtask

    task automatic do_run(input logic [15:0] len);
        logic stop;
        int   left;
        @(negedge clk);
        step_req = 1'b1; step_len = len;
        @(negedge clk);
        step_req = 1'b0;
        if (!m_busy || len == 0) begin
            // R9: idle request ignored, zero length finishes at once
            chk("R9", "step_done", {31'd0, step_done}, {31'd0, m_busy});
            chk("R9", "addr_valid", {31'd0, addr_valid}, 32'd0);
            chk("R9", "dst unchanged", {11'd0, dst_addr}, m_busy ? m_d : {11'd0, dst_addr});
            return;
        end
        left = int'(len);
        forever begin
            logic ack;
            chk("R12", "addr_valid", {31'd0, addr_valid}, 32'd1);
            chk(m_tag, "pat_addr", {11'd0, pat_addr}, e_pat());
            chk(m_tag, "src_addr", {11'd0, src_addr}, e_src());
            chk(m_tag, "dst_addr", {11'd0, dst_addr}, m_d);
            ack = ($urandom % 4) != 0;
            mem_ack = ack;
            step_req = ($urandom % 5) == 0;   // R9: ignored during a run
            @(negedge clk);
            mem_ack = 1'b0; step_req = 1'b0;
            if (ack) begin
                m_pixel(stop);
                left--;
                if (stop || left == 0) break;
            end else begin
                m_tag = "R12";
            end
        end
        chk("R9", "step_done at run end", {31'd0, step_done}, 32'd1);
        chk("R12", "addr_valid after run", {31'd0, addr_valid}, 32'd0);
        chk("R7", "busy after run", {31'd0, busy}, {31'd0, m_busy});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk("R13", "busy", {31'd0, busy}, 32'd0);
        chk("R13", "addr_valid", {31'd0, addr_valid}, 32'd0);
        chk("R13", "step_done", {31'd0, step_done}, 32'd0);
        chk("R13", "status", {24'd0, status}, 32'd0);

        // R9 idle request ignored
        do_run(16'd4);

        // R1 R2: mask 7, 2 rows, Y alignment on
        do_launch(21'h1234D, 21'h00400, 21'h08000, 16'd31, 16'd15, 16'd639,
                  8'h13, 8'h02, 2'b00, 16'd3, 16'd2, 3'd0);
        chk("R2", "aligned pattern first address", {11'd0, pat_addr}, 32'h12345);
        while (m_busy) do_run(16'd5);

        // R2: bit 7 set skips Y alignment
        do_launch(21'h1234D, 21'h00400, 21'h08000, 16'd7, 16'd15, 16'd99,
                  8'h93, 8'h12, 2'b00, 16'd2, 16'd3, 3'd4);
        chk("R2", "unaligned pattern first address", {11'd0, pat_addr}, 32'h1234D);
        while (m_busy) do_run(16'd7);

        // R10 destination wraps across the top of the space
        do_launch(21'h000F0, 21'h1FFFFD, 21'h1FFFFE, 16'd3, 16'd3, 16'd3,
                  8'h07, 8'h07, 2'b00, 16'd3, 16'd1, 3'd0);
        do_run(16'd3);
        chk("R10", "dst after wrap", {11'd0, dst_addr}, 32'h00001);
        while (m_busy) do_run(16'd3);

        // R8 CPU-fed stops at each row end
        do_launch(21'h00100, 21'h00200, 21'h00300, 16'd8, 16'd8, 16'd8,
                  8'h02, 8'h00, 2'b00, 16'd2, 16'd1, 3'd1);
        do_run(16'd10);
        chk("R8", "busy held at row pause", {31'd0, busy}, 32'd1);
        do_run(16'd0);
        while (m_busy) do_run(16'd10);

        // R4 R5 reverse both axes
        do_launch(21'h04020, 21'h05010, 21'h06000, 16'd15, 16'd15, 16'd63,
                  8'h24, 8'h13, 2'b11, 16'd4, 16'd4, 3'd2);
        while (m_busy) do_run(16'd6);

        // random mix
        for (int i = 0; i < 40; i++) begin
            int guard;
            do_launch(21'($urandom), 21'($urandom), 21'($urandom),
                      16'($urandom % 64), 16'($urandom % 64), 16'($urandom % 1024),
                      8'($urandom), 8'($urandom), 2'($urandom),
                      16'($urandom % 5), 16'($urandom % 4), 3'($urandom));
            guard = 0;
            while (m_busy && guard < 100) begin
                do_run(16'($urandom % 7));
                guard++;
            end
        end
        do_run(16'd2);   // R9 after completion: ignored

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule